// File: doc/BRIEF.md
# Masked vector lane writeback unit

This block builds the destination vector for a packed operation on 64-bit elements in a register file that is up to 512 bits wide. It takes the old destination value, the first source vector, the second source (a full vector, or in the masked form a single 64-bit value copied into every lane), and three controls: an encoding form, a vector length and a lane write mask with a zeroing flag. It presents the lane operands to a companion compute stage, which works out first-source lane divided by second-operand lane, and takes back the per-lane results in the same cycle. It then decides lane by lane what is written.

The three encoding forms treat the part of the destination outside the operation differently. The legacy two-operand form preserves the old destination above 128 bits. The unmasked three-operand form clears everything above the operation length. The masked form clears everything above the operation length, and inside it either merges or zeroes each lane that the mask does not select. A form and length pair that is not allowed raises an error and leaves the destination as it was. The result is registered behind a one-cycle valid handshake.

Top module: `vwb_unit`

## Requirements
- R1: Lane i occupies bits 64i+63:64i. The vector length code 0, 1 or 2 selects 128, 256 or 512 bits, which gives 2, 4 or 8 active lanes. The first source is presented unchanged on `cmp_a`, and every written active lane takes `cmp_res`, the result the compute stage returns for (`cmp_a` lane, `cmp_b` lane).
- R2: When the form is masked (code 2) and `bcast` is set, every lane of `cmp_b` equals `src2[63:0]`. In every other case `cmp_b` equals `src2`, and `bcast` has no effect.
- R3: In the masked form, an active lane whose mask bit is set takes the result. An active lane whose mask bit is clear keeps the old destination lane when `zeroing` is 0, and is zero when `zeroing` is 1.
- R4: In the masked form, the lanes above the active count are zero, and the mask bits of those lanes have no effect on the output.
- R5: In the unmasked three-operand form (code 1), the active lanes take the result and all bits above the length, up to bit 511, are zero.
- R6: In the legacy form (code 0), lanes 0 and 1 take the result and bits 511:128 equal the old destination.
- R7: The legal pairs are: legacy with 128; unmasked with 128 or 256; masked with 128, 256 or 512. Form code 3 and length code 3 are never legal. A valid input with an illegal pair produces `out_err`=1 and `out_dst` equal to the old destination. A legal pair produces `out_err`=0.
- R8: `out_valid` equals `in_valid` from the previous cycle, and the output fields are captured on that edge. A synchronous active-high `rst` clears `out_valid` and `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| form | input | 2 | Encoding form: 0 legacy, 1 unmasked, 2 masked |
| vlen | input | 2 | Length code: 0 = 128, 1 = 256, 2 = 512 |
| old_dst | input | 512 | Previous destination value |
| src1 | input | 512 | First source vector (dividends) |
| src2 | input | 512 | Second source vector, or scalar in bits 63:0 |
| bcast | input | 1 | Replicate src2[63:0] in masked form |
| wmask | input | 8 | Lane write mask |
| zeroing | input | 1 | Zero unselected lanes instead of merging |
| cmp_a | output | 512 | First-operand lanes to compute stage |
| cmp_b | output | 512 | Second-operand lanes to compute stage |
| cmp_res | input | 512 | Per-lane results from compute stage |
| out_valid | output | 1 | Result valid |
| out_dst | output | 512 | Final destination vector |
| out_err | output | 1 | Illegal form and length pair |

## Verification
The operand lanes on `cmp_b` are combinational, so the bench checks them one time step after it drives the inputs, in the same cycle. The destination, the error flag and the valid flag pass through a single register. Inputs are driven on a falling edge, and those outputs are sampled on the next falling edge, after exactly one rising edge. The bench derives the expected destination from the requirement rules, using its own stand-in compute stage that returns the lane difference, and checks the valid flag in the cycle after it is dropped and in the cycle after a reset.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_PLAIN  = 2'd1,
    FORM_MASKED = 2'd2,
    FORM_RSVD   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_RSVD = 2'd3
  } vlen_e;
endpackage

// File: rtl/vwb_decode.sv
module vwb_decode #(
  parameter int LANES = 8
) (
  input  vwb_pkg::form_e   form,
  input  vwb_pkg::vlen_e   vlen,
  output logic             legal,
  output logic [LANES-1:0] active
);
  import vwb_pkg::*;
  localparam int CW = $clog2(LANES) + 2;

  logic [CW-1:0] nlanes;

  always_comb begin
    nlanes = CW'(2) << vlen;
    unique case (form)
      FORM_LEGACY: legal = (vlen == LEN_128);
      FORM_PLAIN:  legal = (vlen == LEN_128) || (vlen == LEN_256);
      FORM_MASKED: legal = (vlen != LEN_RSVD);
      default:     legal = 1'b0;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_act
    assign active[i] = (CW'(i) < nlanes);
  end
endmodule

// File: rtl/vwb_opsel.sv
module vwb_opsel #(
  parameter int LANES = 8,
  parameter int EW    = 64
) (
  input  logic [LANES*EW-1:0] src2,
  input  logic                bcast_en,
  output logic [LANES*EW-1:0] op_b
);
  for (genvar i = 0; i < LANES; i++) begin : g_b
    assign op_b[i*EW +: EW] = bcast_en ? src2[EW-1:0] : src2[i*EW +: EW];
  end
endmodule

// File: rtl/vwb_lane.sv
module vwb_lane #(
  parameter int EW = 64
) (
  input  vwb_pkg::form_e form,
  input  logic           legal,
  input  logic           active,
  input  logic           mbit,
  input  logic           zeroing,
  input  logic [EW-1:0]  old_val,
  input  logic [EW-1:0]  res,
  output logic [EW-1:0]  d
);
  import vwb_pkg::*;

  always_comb begin
    if (!legal)
      d = old_val;
    else if (!active)
      d = (form == FORM_LEGACY) ? old_val : '0;
    else if (form != FORM_MASKED || mbit)
      d = res;
    else
      d = zeroing ? '0 : old_val;
  end
endmodule

// File: rtl/vwb_unit.sv
module vwb_unit #(
  parameter int LANES = 8,
  parameter int EW    = 64,
  localparam int VW   = LANES * EW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       form,
  input  logic [1:0]       vlen,
  input  logic [VW-1:0]    old_dst,
  input  logic [VW-1:0]    src1,
  input  logic [VW-1:0]    src2,
  input  logic             bcast,
  input  logic [LANES-1:0] wmask,
  input  logic             zeroing,
  output logic [VW-1:0]    cmp_a,
  output logic [VW-1:0]    cmp_b,
  input  logic [VW-1:0]    cmp_res,
  output logic             out_valid,
  output logic [VW-1:0]    out_dst,
  output logic             out_err
);
  import vwb_pkg::*;

  form_e            form_t;
  vlen_e            vlen_t;
  logic             legal;
  logic [LANES-1:0] active;
  logic [VW-1:0]    next_dst;

  assign form_t = form_e'(form);
  assign vlen_t = vlen_e'(vlen);
  assign cmp_a  = src1;

  vwb_decode #(.LANES(LANES)) u_dec (
    .form(form_t), .vlen(vlen_t), .legal(legal), .active(active)
  );

  vwb_opsel #(.LANES(LANES), .EW(EW)) u_sel (
    .src2(src2), .bcast_en(bcast && (form_t == FORM_MASKED)), .op_b(cmp_b)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vwb_lane #(.EW(EW)) u_lane (
      .form(form_t), .legal(legal), .active(active[i]), .mbit(wmask[i]),
      .zeroing(zeroing), .old_val(old_dst[i*EW +: EW]),
      .res(cmp_res[i*EW +: EW]), .d(next_dst[i*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_err <= !legal;
    end
    if (in_valid && !rst) out_dst <= next_dst;
  end
endmodule

// File: rtl/vwb_unit_chk.sv
module vwb_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   form,
  input logic [1:0]   vlen,
  input logic [511:0] old_dst,
  input logic [511:0] src2,
  input logic         bcast,
  input logic [511:0] cmp_b,
  input logic         out_valid,
  input logic [511:0] out_dst,
  input logic         out_err
);
  logic bad_pair;
  assign bad_pair = (form == 2'd3) || (vlen == 2'd3) ||
                    (form == 2'd0 && vlen != 2'd0) ||
                    (form == 2'd1 && vlen == 2'd2);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("valid lost"); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("spurious valid"); // R8
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    in_valid && bad_pair |=> out_err && out_dst == $past(old_dst)) else $error("illegal pair"); // R7
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (rst)
    in_valid && form == 2'd0 && vlen == 2'd0 |=> out_dst[511:128] == $past(old_dst[511:128]))
    else $error("legacy upper"); // R6
  AST_PLAIN_UPPER: assert property (@(posedge clk) disable iff (rst)
    in_valid && form == 2'd1 && vlen == 2'd0 |=> out_dst[511:128] == '0) else $error("plain upper"); // R5
  AST_BCAST_SAME: assert property (@(posedge clk) disable iff (rst)
    form == 2'd2 && bcast |-> cmp_b[511:448] == src2[63:0] && cmp_b[255:192] == src2[63:0])
    else $error("bcast"); // R2
endmodule

bind vwb_unit vwb_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .form(form), .vlen(vlen),
  .old_dst(old_dst), .src2(src2), .bcast(bcast), .cmp_b(cmp_b),
  .out_valid(out_valid), .out_dst(out_dst), .out_err(out_err)
);

// File: tb/sim_vwb_unit.sv
`timescale 1ns/1ps
module sim_vwb_unit;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic [1:0]   form = 0, vlen = 0;
  logic [511:0] old_dst = '0, src1 = '0, src2 = '0;
  logic         bcast = 0, zeroing = 0;
  logic [7:0]   wmask = 0;
  logic [511:0] cmp_a, cmp_b, cmp_res;
  logic         out_valid, out_err;
  logic [511:0] out_dst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vwb_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form(form), .vlen(vlen),
    .old_dst(old_dst), .src1(src1), .src2(src2), .bcast(bcast), .wmask(wmask),
    .zeroing(zeroing), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_res(cmp_res),
    .out_valid(out_valid), .out_dst(out_dst), .out_err(out_err)
  );

  // stand-in compute stage: lane difference
  always_comb
    for (int i = 0; i < 8; i++)
      cmp_res[i*64 +: 64] = cmp_a[i*64 +: 64] - cmp_b[i*64 +: 64];

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int f, input int l, input int m, input bit z, input bit bc, input int seed);
    logic [511:0] eb, ed;
    logic [63:0] a, b, o;
    bit ok_pair;
    int n;
    string tag;
    @(negedge clk);
    in_valid = 1; form = 2'(f); vlen = 2'(l); wmask = 8'(m); zeroing = z; bcast = bc;
    for (int i = 0; i < 8; i++) begin
      src1[i*64 +: 64]    = 64'h0123_4567_89AB_CDEF * 64'(seed*8 + i + 1);
      src2[i*64 +: 64]    = 64'h9E37_79B9_7F4A_7C15 * 64'(seed*8 + i + 3);
      old_dst[i*64 +: 64] = ~(64'h5555_0000_AAAA_1111 * 64'(seed + i + 7));
    end
    ok_pair = (f == 0 && l == 0) || (f == 1 && l <= 1) || (f == 2 && l <= 2);
    n = (l == 3) ? 0 : (2 << l);
    for (int i = 0; i < 8; i++) begin
      a = src1[i*64 +: 64];
      b = (f == 2 && bc) ? src2[63:0] : src2[i*64 +: 64];
      o = old_dst[i*64 +: 64];
      eb[i*64 +: 64] = b;
      if (!ok_pair)              ed[i*64 +: 64] = o;
      else if (i >= n)           ed[i*64 +: 64] = (f == 0) ? o : 64'd0;
      else if (f != 2 || m[i])   ed[i*64 +: 64] = a - b;
      else                       ed[i*64 +: 64] = z ? 64'd0 : o;
    end
    tag = !ok_pair ? "R7" : (f == 0) ? "R6" : (f == 1) ? "R5 R1" : "R3 R4 R1";
    #1;
    chk(cmp_b == eb, "R2 operand lanes", cmp_b, eb);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid", 512'(out_valid), 512'(1));
    chk(out_err == !ok_pair, "R7 err", 512'(out_err), 512'(!ok_pair));
    chk(out_dst == ed, tag, out_dst, ed);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && out_err == 0, "R8 reset", 512'({out_valid, out_err}), 512'(0));
    rst = 0;
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 4; l++)
        if (f == 2)
          for (int m = 0; m < 256; m++)
            for (int z = 0; z < 2; z++)
              run_vec(f, l, m, z[0], m[0] ^ m[3], m * 2 + z);
        else
          for (int k = 0; k < 4; k++)
            run_vec(f, l, k * 85, k[0], k[1], k + 16 * l);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R8 idle", 512'(out_valid), 512'(0));
    in_valid = 1;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(out_valid == 0 && out_err == 0, "R8 reset clears", 512'({out_valid, out_err}), 512'(0));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule